// File: doc/BRIEF.md
# Iterative Integer Divide and Remainder Unit

This unit computes the quotient or the remainder of two XLEN-bit integers. Each operation can be signed or unsigned. It is meant as the division engine beside the execution pipeline of a scalar core. A request carries both operands and three operation flags. The unit takes the request, works through it one quotient bit per clock, and then holds a single XLEN-bit result until the consumer takes it.

Division by zero and the one signed overflow case (the most negative value divided by minus one) never trap. Each of them gives a fixed result. When the `WORD_EN` parameter is set, a word form is also available. It works on the low 32 bits of each operand and sign-extends the 32-bit result to the full width. Clearing `WORD_EN` removes that logic, so the same unit also suits a 32-bit core.

Top module: `div_unit`

## Requirements
- R1: `req_ready` is high only while the unit is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While an operation is in progress or a result is waiting, `req_valid` is ignored and `req_ready` stays low. `req_ready` returns high on the cycle after a result has been taken.
- R2: `rsp_valid` rises XLEN+1 clock edges after the accepting edge. While `rsp_ready` is low, `rsp_valid` stays high and `rsp_data` keeps its value.
- R3: With `req_signed`=0, the quotient is the floor of a/b and the remainder is a mod b, both treating the operands as unsigned.
- R4: With `req_signed`=1, the quotient is the two's-complement quotient rounded toward zero.
- R5: A signed remainder is either zero or has the sign of the dividend, and a = b*q + r holds.
- R6: When the divisor is zero, the quotient is all ones and the remainder equals the dividend.
- R7: When a signed operation divides the most negative value by -1, the quotient is the dividend and the remainder is zero.
- R8: With `req_word`=1 (only when WORD_EN=1), only operand bits 31:0 are used. The 32-bit result is sign-extended to XLEN. This applies to the unsigned forms and to the zero-divisor results too.
- R9: After reset, `req_ready` is 1 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request may be taken |
| req_signed | input | 1 | 1: signed operands, 0: unsigned |
| req_rem | input | 1 | 1: return the remainder, 0: return the quotient |
| req_word | input | 1 | 1: word form on bits 31:0 (ignored when WORD_EN=0) |
| req_a | input | XLEN | Dividend |
| req_b | input | XLEN | Divisor |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_data | output | XLEN | Result |

## Verification
Several properties are checked on every cycle by the assertions:
- the handshake refusal while busy (R1);
- the exact latency from acceptance to a valid result (R2);
- that the result is held stable while the consumer stalls (R2);
- that every word result has its upper bits equal to bit 31 (R8);
- that an unsigned or signed quotient by zero is all ones (R6).

The arithmetic values can only be shown by the bench scenarios, which compare each result against a behavioural reference. These cover rounding toward zero with mixed operand signs, the remainder sign rule, the overflow result, the zero-divisor remainder, and word operands with garbage in their upper halves.

// File: rtl/div_pkg.sv
package div_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RUN,
      ST_FIX,
      ST_DONE
   } div_state_e;

   typedef struct packed {
      logic sgn;
      logic rem;
      logic word;
   } div_op_t;
endpackage

// File: rtl/div_prep.sv
// Operand preparation: word selection, magnitudes, result signs and special cases.
module div_prep
   import div_pkg::*;
#(
   parameter int XLEN    = 64,
   parameter bit WORD_EN = 1
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  div_op_t         op,
   output logic [XLEN-1:0] dvd_mag,
   output logic [XLEN-1:0] dvs_mag,
   output logic            neg_quo,
   output logic            neg_rem,
   output logic            by_zero,
   output logic            ovf,
   output logic [XLEN-1:0] dvd_res
);
   localparam int WLEN = 32;
   localparam logic [XLEN-1:0] XMIN = {1'b1, {(XLEN-1){1'b0}}};

   logic [XLEN-1:0] a_w, b_w, a_v, b_v, dvd_sx;
   logic            use_word, ovf_w, zero_w, a_neg, b_neg;

   generate
      if (WORD_EN) begin : g_word
         always_comb begin
            if (op.sgn) begin
               a_w = {{(XLEN-WLEN){a[WLEN-1]}}, a[WLEN-1:0]};
               b_w = {{(XLEN-WLEN){b[WLEN-1]}}, b[WLEN-1:0]};
            end else begin
               a_w = {{(XLEN-WLEN){1'b0}}, a[WLEN-1:0]};
               b_w = {{(XLEN-WLEN){1'b0}}, b[WLEN-1:0]};
            end
         end
         assign use_word = op.word;
         assign dvd_sx   = {{(XLEN-WLEN){a[WLEN-1]}}, a[WLEN-1:0]};
         assign ovf_w    = (a[WLEN-1:0] == {1'b1, {(WLEN-1){1'b0}}}) && (&b[WLEN-1:0]);
         assign zero_w   = ~|b[WLEN-1:0];
      end else begin : g_noword
         assign a_w      = a;
         assign b_w      = b;
         assign use_word = 1'b0;
         assign dvd_sx   = a;
         assign ovf_w    = 1'b0;
         assign zero_w   = 1'b0;
      end
   endgenerate

   always_comb begin
      a_v     = use_word ? a_w : a;
      b_v     = use_word ? b_w : b;
      a_neg   = op.sgn & a_v[XLEN-1];
      b_neg   = op.sgn & b_v[XLEN-1];
      dvd_mag = a_neg ? (~a_v + 1'b1) : a_v;
      dvs_mag = b_neg ? (~b_v + 1'b1) : b_v;
      neg_quo = a_neg ^ b_neg;
      neg_rem = a_neg;
      by_zero = use_word ? zero_w : ~|b;
      ovf     = op.sgn & (use_word ? ovf_w : ((a == XMIN) && (&b)));
      dvd_res = use_word ? dvd_sx : a;
   end
endmodule

// File: rtl/div_core.sv
// Restoring divider on magnitudes, one quotient bit per step.
module div_core #(
   parameter int XLEN = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            step,
   input  logic [XLEN-1:0] dvd,
   input  logic [XLEN-1:0] dvs,
   output logic [XLEN-1:0] quo,
   output logic [XLEN-1:0] rem
);
   logic [XLEN-1:0] dvs_q;
   logic [XLEN:0]   rem_sh, diff;

   always_comb begin
      rem_sh = {rem, quo[XLEN-1]};
      diff   = rem_sh - {1'b0, dvs_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quo   <= '0;
         rem   <= '0;
         dvs_q <= '0;
      end else if (load) begin
         quo   <= dvd;
         rem   <= '0;
         dvs_q <= dvs;
      end else if (step) begin
         if (!diff[XLEN]) begin
            rem <= diff[XLEN-1:0];
            quo <= {quo[XLEN-2:0], 1'b1};
         end else begin
            rem <= rem_sh[XLEN-1:0];
            quo <= {quo[XLEN-2:0], 1'b0};
         end
      end
   end
endmodule

// File: rtl/div_fix.sv
// Sign correction, special-case results and word sign extension.
module div_fix #(
   parameter int XLEN    = 64,
   parameter bit WORD_EN = 1
) (
   input  logic [XLEN-1:0] quo,
   input  logic [XLEN-1:0] rem,
   input  logic            neg_quo,
   input  logic            neg_rem,
   input  logic            by_zero,
   input  logic            ovf,
   input  logic            want_rem,
   input  logic            word,
   input  logic [XLEN-1:0] dvd_res,
   output logic [XLEN-1:0] result
);
   localparam int WLEN = 32;

   logic [XLEN-1:0] q_s, r_s, sel;

   always_comb begin
      q_s = neg_quo ? (~quo + 1'b1) : quo;
      r_s = neg_rem ? (~rem + 1'b1) : rem;
      if (by_zero)  sel = want_rem ? dvd_res : '1;
      else if (ovf) sel = want_rem ? '0 : dvd_res;
      else          sel = want_rem ? r_s : q_s;
   end

   generate
      if (WORD_EN) begin : g_wext
         assign result = word ? {{(XLEN-WLEN){sel[WLEN-1]}}, sel[WLEN-1:0]} : sel;
      end else begin : g_full
         assign result = sel;
      end
   endgenerate
endmodule

// File: rtl/div_unit.sv
module div_unit
   import div_pkg::*;
#(
   parameter int XLEN    = 64,
   parameter bit WORD_EN = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic            req_signed,
   input  logic            req_rem,
   input  logic            req_word,
   input  logic [XLEN-1:0] req_a,
   input  logic [XLEN-1:0] req_b,
   output logic            rsp_valid,
   input  logic            rsp_ready,
   output logic [XLEN-1:0] rsp_data
);
   localparam int CW = $clog2(XLEN);

   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("div_unit: XLEN must be 32 or 64");
      end
      if (WORD_EN && XLEN <= 32) begin : g_bad_word
         $error("div_unit: word forms need XLEN above 32");
      end
   endgenerate

   div_state_e      state;
   logic [CW-1:0]   cnt;
   div_op_t         op_in, op_q;
   logic [XLEN-1:0] dvd_mag, dvs_mag, dvd_res, dvd_res_q, quo, rem, fix_out;
   logic            neg_quo, neg_rem, by_zero, ovf;
   logic            neg_quo_q, neg_rem_q, div_zero_q, ovf_q;
   logic            accept, op_word_q, op_rem_q;

   assign op_in     = '{sgn: req_signed, rem: req_rem, word: req_word};
   assign req_ready = (state == ST_IDLE);
   assign rsp_valid = (state == ST_DONE);
   assign accept    = req_valid & req_ready;
   assign op_word_q = op_q.word;
   assign op_rem_q  = op_q.rem;

   div_prep #(.XLEN(XLEN), .WORD_EN(WORD_EN)) u_prep (
      .a(req_a), .b(req_b), .op(op_in),
      .dvd_mag(dvd_mag), .dvs_mag(dvs_mag),
      .neg_quo(neg_quo), .neg_rem(neg_rem),
      .by_zero(by_zero), .ovf(ovf), .dvd_res(dvd_res)
   );

   div_core #(.XLEN(XLEN)) u_core (
      .clk(clk), .rst_n(rst_n),
      .load(accept), .step(state == ST_RUN),
      .dvd(dvd_mag), .dvs(dvs_mag),
      .quo(quo), .rem(rem)
   );

   div_fix #(.XLEN(XLEN), .WORD_EN(WORD_EN)) u_fix (
      .quo(quo), .rem(rem),
      .neg_quo(neg_quo_q), .neg_rem(neg_rem_q),
      .by_zero(div_zero_q), .ovf(ovf_q),
      .want_rem(op_q.rem), .word(op_q.word),
      .dvd_res(dvd_res_q), .result(fix_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cnt        <= '0;
         op_q       <= '0;
         neg_quo_q  <= 1'b0;
         neg_rem_q  <= 1'b0;
         div_zero_q <= 1'b0;
         ovf_q      <= 1'b0;
         dvd_res_q  <= '0;
         rsp_data   <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (accept) begin
               state      <= ST_RUN;
               cnt        <= '0;
               op_q       <= op_in;
               neg_quo_q  <= neg_quo;
               neg_rem_q  <= neg_rem;
               div_zero_q <= by_zero;
               ovf_q      <= ovf;
               dvd_res_q  <= dvd_res;
            end
            ST_RUN: begin
               cnt <= cnt + 1'b1;
               if (cnt == CW'(XLEN-1)) state <= ST_FIX;
            end
            ST_FIX: begin
               rsp_data <= fix_out;
               state    <= ST_DONE;
            end
            ST_DONE: if (rsp_ready) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/div_unit_chk.sv
module div_unit_chk #(
   parameter int XLEN    = 64,
   parameter bit WORD_EN = 1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic            rsp_valid,
   input logic            rsp_ready,
   input logic [XLEN-1:0] rsp_data,
   input logic            word_q,
   input logic            zero_q,
   input logic            rem_q
);
   localparam int WLEN = 32;
   localparam int LW   = $clog2(XLEN + 2) + 1;

   logic [LW-1:0] lat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lat <= '0;
      else if (req_valid && req_ready) lat <= '0;
      else if (!(&lat)) lat <= lat + 1'b1;
   end

   assert_busy_refuse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);
   assert_accept_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
   assert_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_ready) |=> (req_ready && !rsp_valid));
   assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rsp_valid) |-> (lat == LW'(XLEN + 1)));
   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
   assert_zero_quo_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && zero_q && !rem_q) |-> (&rsp_data));

   generate
      if (WORD_EN) begin : g_wchk
         assert_word_sext_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (rsp_valid && word_q) |->
               (rsp_data[XLEN-1:WLEN] == {(XLEN-WLEN){rsp_data[WLEN-1]}}));
      end
   endgenerate
endmodule

bind div_unit div_unit_chk #(.XLEN(XLEN), .WORD_EN(WORD_EN)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .req_valid(req_valid), .req_ready(req_ready),
   .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
   .word_q(op_word_q), .zero_q(div_zero_q), .rem_q(op_rem_q)
);

// File: tb/tb_div_unit.sv
`timescale 1ns/1ps
module tb_div_unit;
   localparam int XLEN = 64;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0, req_signed = 1'b0, req_rem = 1'b0, req_word = 1'b0;
   logic [XLEN-1:0] req_a = '0, req_b = '0;
   logic            rsp_ready = 1'b0;
   logic            req_ready, rsp_valid;
   logic [XLEN-1:0] rsp_data;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   div_unit #(.XLEN(XLEN), .WORD_EN(1)) dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_signed(req_signed), .req_rem(req_rem), .req_word(req_word),
      .req_a(req_a), .req_b(req_b),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] ref_div(input logic [63:0] a, input logic [63:0] b,
                                           input bit sg, input bit rm, input bit wd);
      logic [31:0] r32;
      logic [63:0] r64;
      int          sa, sb;
      longint      la, lb;
      if (wd) begin
         sa = a[31:0];
         sb = b[31:0];
         if (b[31:0] == 0)                                       r32 = rm ? a[31:0] : 32'hffff_ffff;
         else if (sg && a[31:0] == 32'h8000_0000 && sb == -1)    r32 = rm ? 32'h0 : a[31:0];
         else if (sg)                                            r32 = rm ? 32'(sa % sb) : 32'(sa / sb);
         else                                                    r32 = rm ? a[31:0] % b[31:0] : a[31:0] / b[31:0];
         return {{32{r32[31]}}, r32};
      end
      la = a;
      lb = b;
      if (b == 0)                                                r64 = rm ? a : '1;
      else if (sg && a == 64'h8000_0000_0000_0000 && lb == -1)   r64 = rm ? '0 : a;
      else if (sg)                                               r64 = rm ? 64'(la % lb) : 64'(la / lb);
      else                                                       r64 = rm ? a % b : a / b;
      return r64;
   endfunction

   // Reference model: 0 idle, 1 busy, 2 result waiting
   int          m_state = 0;
   int          m_cnt = 0;
   logic [63:0] m_exp = '0;
   string       m_tag = "";
   string       cur_tag = "";
   bit          started = 1'b0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_state <= 0;
         m_cnt   <= 0;
      end else begin
         case (m_state)
            0: if (req_valid) begin
               m_state <= 1;
               m_cnt   <= XLEN + 1;
               m_exp   <= ref_div(req_a, req_b, req_signed, req_rem, req_word);
               m_tag   <= cur_tag;
            end
            1: begin
               if (m_cnt == 1) m_state <= 2;
               m_cnt <= m_cnt - 1;
            end
            default: if (rsp_ready) m_state <= 0;
         endcase
      end
   end

   always @(negedge clk) begin
      if (rst_n && started) begin
         chk(req_ready == (m_state == 0), "R1 req_ready vs model", 64'(req_ready), 64'(m_state == 0));
         chk(rsp_valid == (m_state == 2), "R2 rsp_valid vs model", 64'(rsp_valid), 64'(m_state == 2));
         if (m_state == 2 && rsp_valid)
            chk(rsp_data == m_exp, m_tag, rsp_data, m_exp);
      end
   end

   task automatic run_op(input logic [63:0] a, input logic [63:0] b, input bit sg,
                         input bit rm, input bit wd, input string tag,
                         input int hold, input bit poke);
      @(negedge clk);
      req_a = a; req_b = b; req_signed = sg; req_rem = rm; req_word = wd;
      cur_tag = tag;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (poke) begin
         // R1: a request during the busy window must be ignored
         req_a = ~a; req_b = b + 64'd3; req_rem = ~rm;
         req_valid = 1'b1;
         repeat (5) @(negedge clk);
         req_valid = 1'b0;
      end
      while (!rsp_valid) @(negedge clk);
      repeat (hold) @(negedge clk);
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R9 reset ready", 64'(req_ready), 64'd1);
      chk(rsp_valid == 1'b0, "R9 reset valid", 64'(rsp_valid), 64'd0);
      started = 1'b1;

      run_op(64'd100, 64'd7, 0, 0, 0, "R3 unsigned quotient", 0, 0);
      run_op(64'd100, 64'd7, 0, 1, 0, "R3 unsigned remainder", 0, 0);
      run_op(64'hffff_ffff_ffff_ffff, 64'd3, 0, 0, 0, "R3 unsigned max quotient", 0, 0);
      run_op(-64'sd7, 64'd2, 1, 0, 0, "R4 neg/pos quotient", 0, 0);
      run_op(64'd7, -64'sd2, 1, 0, 0, "R4 pos/neg quotient", 0, 0);
      run_op(-64'sd7, -64'sd2, 1, 0, 0, "R4 neg/neg quotient", 0, 0);
      run_op(-64'sd7, 64'd2, 1, 1, 0, "R5 neg dividend remainder", 0, 0);
      run_op(64'd7, -64'sd2, 1, 1, 0, "R5 pos dividend remainder", 0, 0);
      run_op(-64'sd8, 64'd4, 1, 1, 0, "R5 zero remainder", 0, 0);
      run_op(64'd1234, 64'd0, 0, 0, 0, "R6 unsigned by zero quotient", 0, 0);
      run_op(-64'sd55, 64'd0, 1, 0, 0, "R6 signed by zero quotient", 0, 0);
      run_op(-64'sd55, 64'd0, 1, 1, 0, "R6 signed by zero remainder", 0, 0);
      run_op(64'h8000_0000_0000_0000, '1, 1, 0, 0, "R7 overflow quotient", 0, 0);
      run_op(64'h8000_0000_0000_0000, '1, 1, 1, 0, "R7 overflow remainder", 0, 0);
      run_op(64'hdead_beef_ffff_fff9, 64'h1234_0000_0000_0002, 1, 0, 1, "R8 word signed quotient", 0, 0);
      run_op(64'h1111_1111_ffff_ffff, 64'h5555_5555_0000_0001, 0, 0, 1, "R8 word unsigned sign extend", 0, 0);
      run_op(64'hffff_0000_8000_0005, 64'h0000_0001_0000_0000, 0, 1, 1, "R8 word by zero remainder", 0, 0);
      run_op(64'h0000_0000_8000_0000, 64'h7777_7777_ffff_ffff, 1, 0, 1, "R8 word overflow quotient", 0, 0);
      run_op(64'h0000_0000_8000_0007, 64'd5, 1, 1, 1, "R8 word signed remainder", 0, 0);
      run_op(64'd999, 64'd10, 0, 0, 0, "R1 busy request ignored", 0, 1);
      run_op(-64'sd1000, 64'd33, 1, 1, 0, "R2 result held while stalled", 4, 0);

      for (int i = 0; i < 24; i++) begin
         logic [63:0] ra, rb;
         ra = {$urandom, $urandom};
         rb = (i % 3 == 0) ? 64'($urandom % 1000) : {$urandom, $urandom} >> (i % 40);
         run_op(ra, rb, i[0], i[1], i[2], "R5 mixed operand sweep", i % 3, 0);
      end

      repeat (3) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule